// File: doc/BRIEF.md
# Microcontroller Power-Mode Controller

This block sequences the two low-power states of a small 8-bit microcontroller core. Software writes a byte to the power-control register. Bit 0 requests the light sleep state (Idle). Bit 1 requests the deep sleep state (Power-down). From these writes and a few wake inputs the block produces four kinds of output: a CPU-halt signal, a clock-gate enable for the core and peripherals, an oscillator enable, and the forced levels for the two external bus strobes (address-latch strobe and program-store strobe).

In Idle the clocks keep running and only the CPU is halted. Idle ends when any enabled interrupt begins service. In Power-down the gated clock and the oscillator are off. The only way out is a hardware reset, or an enabled external pin that is configured as level-sensitive. That pin must be held low for a minimum number of clocks while the oscillator restarts, and it must then return high. After that, the block waits for the oscillator-stable indication before it opens the clock gate and releases the CPU. Entering or leaving a mode clears no state except the mode bits and the wake-hold counter.

Top module: `pmc_top`

## Requirements
- R1: While the asynchronous active-low reset is asserted, and afterwards until a mode is entered, the outputs are: cpuHalt=0, clkGateEn=1, oscEn=1, strobeForce=0, aleLevel=0, psenLevel=0.
- R2: A register write with bit 0 set and bit 1 clear (value 01h) enters Idle at the next clock edge. In Idle the outputs are cpuHalt=1, clkGateEn=1, oscEn=1, strobeForce=1, aleLevel=1, psenLevel=1.
- R3: A register write with bit 1 set (value 02h) enters Power-down at the next clock edge. With no qualified wake pin low, the outputs are cpuHalt=1, clkGateEn=0, oscEn=0, strobeForce=1, aleLevel=0, psenLevel=0.
- R4: A write with both bit 0 and bit 1 set (03h) enters Power-down, not Idle.
- R5: A write with bits 0 and 1 both clear (for example 00h or 04h) leaves the run state unchanged.
- R6: In Idle, an asserted irqPending returns the block to run at the next clock edge, with the R1 output values.
- R7: In Power-down, oscEn is 1 in the same cycle that an external pin is low while its enable bit and its level-mode bit are both 1.
- R8: If a qualified pin is held low for at least HOLD_CYCLES clock edges and is then released high, the next edge enters a stabilise phase. In that phase cpuHalt=1, clkGateEn=0, oscEn=1, strobeForce=1, and both strobe levels are 0. Once oscStable is 1, the next edge returns the block to run.
- R9: If a qualified pin is released before HOLD_CYCLES edges, the block stays in Power-down and the hold count restarts from zero.
- R10: In Power-down, the following do not wake the block and do not turn on the oscillator: irqPending, a low pin whose level-mode bit is 0, and a low pin whose enable bit is 0.
- R11: Asserting reset while in Power-down restores the R1 outputs at once, without waiting for a clock edge.
- R12: In the stabilise phase, the CPU stays halted and the clock gate stays shut for as long as oscStable is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock (always running) |
| rstN | input | 1 | Asynchronous hardware reset, active low |
| regWrEn | input | 1 | Power-control register write strobe |
| regWrData | input | 8 | Write data; bit 0 requests Idle, bit 1 requests Power-down |
| irqPending | input | 1 | Enabled interrupt starting service |
| extIntN | input | NUM_EXT | External interrupt pins, active low |
| extIntEn | input | NUM_EXT | Per-pin interrupt enable |
| extLevelMode | input | NUM_EXT | Per-pin mode: 1 = level-sensitive, 0 = edge |
| oscStable | input | 1 | Oscillator has settled |
| cpuHalt | output | 1 | Halts the CPU program counter |
| clkGateEn | output | 1 | Enable for the gated core/peripheral clock |
| oscEn | output | 1 | Oscillator enable |
| strobeForce | output | 1 | Bus strobes are overridden |
| aleLevel | output | 1 | Forced address-latch strobe level |
| psenLevel | output | 1 | Forced program-store strobe level |

## Verification
The mode state is held in one register stage, so a write or a wake event shows up on the outputs one clock edge after it is presented. The oscillator enable is the exception: it follows a qualified low pin combinationally in the same cycle. The bench drives inputs on the falling edge and samples one time unit after the next rising edge. For the two combinational cases (oscEn, and the asynchronous reset) it samples one time unit after the falling-edge drive. The hold-time boundary is tested by holding a pin low for exactly HOLD_CYCLES-1 edges and for exactly HOLD_CYCLES edges, with the release counted as the following edge.

// File: rtl/pmc_pkg.sv
package pmc_pkg;
  localparam int IDL_BIT = 0;
  localparam int PD_BIT  = 1;

  typedef enum logic [1:0] {
    ST_RUN  = 2'd0,
    ST_IDLE = 2'd1,
    ST_PD   = 2'd2,
    ST_STAB = 2'd3
  } pmcState_e;

  typedef struct packed {
    logic setIdl;
    logic clrIdl;
    logic setPd;
    logic clrPd;
    logic cntInc;
    logic cntClr;
  } pmcStrobe_t;
endpackage

// File: rtl/pmc_datapath.sv
module pmc_datapath
  import pmc_pkg::*;
#(
  parameter int HOLD_CYCLES = 1024
) (
  input  logic       clk,
  input  logic       rstN,
  input  pmcStrobe_t strb,
  output logic       idlBit,
  output logic       pdBit,
  output logic       cntDone
);
  localparam int CNT_W = $clog2(HOLD_CYCLES + 1);
  localparam logic [CNT_W-1:0] CNT_LIMIT = CNT_W'(HOLD_CYCLES);

  logic [CNT_W-1:0] holdCnt;

  assign cntDone = (holdCnt >= CNT_LIMIT);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      idlBit <= 1'b0;
      pdBit  <= 1'b0;
    end else begin
      if (strb.clrIdl)      idlBit <= 1'b0;
      else if (strb.setIdl) idlBit <= 1'b1;
      if (strb.clrPd)       pdBit  <= 1'b0;
      else if (strb.setPd)  pdBit  <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt <= '0;
    end else if (strb.cntClr) begin
      holdCnt <= '0;
    end else if (strb.cntInc && !cntDone) begin
      holdCnt <= holdCnt + 1'b1;
    end
  end

  AST_MODE_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rstN)
    !(idlBit && pdBit)); // R4
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    holdCnt <= CNT_LIMIT); // R8
  AST_CNT_RESTART: assert property (@(posedge clk) disable iff (!rstN)
    strb.cntClr |=> (holdCnt == '0)); // R9
endmodule

// File: rtl/pmc_ctrl.sv
module pmc_ctrl
  import pmc_pkg::*;
#(
  parameter int NUM_EXT = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  input  logic               irqPending,
  input  logic [NUM_EXT-1:0] extIntN,
  input  logic [NUM_EXT-1:0] extIntEn,
  input  logic [NUM_EXT-1:0] extLevelMode,
  input  logic               oscStable,
  input  logic               cntDone,
  output pmcStrobe_t         strb,
  output pmcState_e          state,
  output logic               cpuHalt,
  output logic               clkGateEn,
  output logic               oscEn,
  output logic               strobeForce,
  output logic               aleLevel,
  output logic               psenLevel
);
  pmcState_e nextState;
  logic      wakeLow;
  logic      wrIdl;
  logic      wrPd;

  assign wakeLow = |(~extIntN & extIntEn & extLevelMode);
  assign wrPd    = regWrEn && regWrData[PD_BIT];
  assign wrIdl   = regWrEn && regWrData[IDL_BIT] && !regWrData[PD_BIT];

  always_comb begin
    nextState = state;
    strb      = '0;
    unique case (state)
      ST_RUN: begin
        if (wrPd) begin
          nextState   = ST_PD;
          strb.setPd  = 1'b1;
          strb.cntClr = 1'b1;
        end else if (wrIdl) begin
          nextState   = ST_IDLE;
          strb.setIdl = 1'b1;
        end
      end
      ST_IDLE: begin
        if (irqPending) begin
          nextState   = ST_RUN;
          strb.clrIdl = 1'b1;
        end
      end
      ST_PD: begin
        if (wakeLow) begin
          strb.cntInc = 1'b1;
        end else if (cntDone) begin
          nextState   = ST_STAB;
          strb.cntClr = 1'b1;
        end else begin
          strb.cntClr = 1'b1;
        end
      end
      ST_STAB: begin
        if (oscStable) begin
          nextState  = ST_RUN;
          strb.clrPd = 1'b1;
        end
      end
      default: nextState = ST_RUN;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_RUN;
    else       state <= nextState;
  end

  always_comb begin
    cpuHalt     = (state != ST_RUN);
    clkGateEn   = (state == ST_RUN) || (state == ST_IDLE);
    oscEn       = (state != ST_PD) || wakeLow;
    strobeForce = (state != ST_RUN);
    aleLevel    = (state == ST_IDLE);
    psenLevel   = (state == ST_IDLE);
  end

  AST_PD_CLOCK_SHUT: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PD) |-> (!clkGateEn && !aleLevel && !psenLevel)); // R3
  AST_EARLY_RELEASE_STAYS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_PD && !wakeLow && !cntDone) |=> (state == ST_PD)); // R9
  AST_HALT_RELEASE_CAUSE: assert property (@(posedge clk) disable iff (!rstN)
    $fell(cpuHalt) |-> ($past(irqPending) || $past(oscStable))); // R6
  AST_STAB_WAITS_OSC: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_STAB && !oscStable) |=> (cpuHalt && !clkGateEn)); // R12
  AST_RUN_OPEN: assert property (@(posedge clk) disable iff (!rstN)
    !cpuHalt |-> (clkGateEn && oscEn && !strobeForce)); // R1
endmodule

// File: rtl/pmc_top.sv
module pmc_top
  import pmc_pkg::*;
#(
  parameter int NUM_EXT     = 2,
  parameter int HOLD_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               regWrEn,
  input  logic [7:0]         regWrData,
  input  logic               irqPending,
  input  logic [NUM_EXT-1:0] extIntN,
  input  logic [NUM_EXT-1:0] extIntEn,
  input  logic [NUM_EXT-1:0] extLevelMode,
  input  logic               oscStable,
  output logic               cpuHalt,
  output logic               clkGateEn,
  output logic               oscEn,
  output logic               strobeForce,
  output logic               aleLevel,
  output logic               psenLevel
);
  pmcStrobe_t strb;
  pmcState_e  state;
  logic       idlBit;
  logic       pdBit;
  logic       cntDone;

  pmc_ctrl #(.NUM_EXT(NUM_EXT)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqPending(irqPending), .extIntN(extIntN), .extIntEn(extIntEn),
    .extLevelMode(extLevelMode), .oscStable(oscStable), .cntDone(cntDone),
    .strb(strb), .state(state), .cpuHalt(cpuHalt), .clkGateEn(clkGateEn),
    .oscEn(oscEn), .strobeForce(strobeForce), .aleLevel(aleLevel),
    .psenLevel(psenLevel)
  );

  pmc_datapath #(.HOLD_CYCLES(HOLD_CYCLES)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .idlBit(idlBit), .pdBit(pdBit), .cntDone(cntDone)
  );

  AST_IDLE_BIT_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_IDLE) == idlBit); // R2
  AST_PD_BIT_TRACKS: assert property (@(posedge clk) disable iff (!rstN)
    ((state == ST_PD) || (state == ST_STAB)) == pdBit); // R3
endmodule

// File: tb/pmc_top_bench.sv
module pmc_top_bench;
  localparam int NUM_EXT = 2;
  localparam int HOLD    = 1024;

  // output word: {cpuHalt, clkGateEn, oscEn, strobeForce, aleLevel, psenLevel}
  localparam logic [5:0] O_RUN  = 6'b011000;
  localparam logic [5:0] O_IDLE = 6'b111111;
  localparam logic [5:0] O_PD   = 6'b100100;
  localparam logic [5:0] O_STAB = 6'b101100;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [7:0] regWrData = 8'h00;
  logic irqPending = 1'b0;
  logic [NUM_EXT-1:0] extIntN = '1;
  logic [NUM_EXT-1:0] extIntEn = 2'b11;
  logic [NUM_EXT-1:0] extLevelMode = 2'b01;
  logic oscStable = 1'b1;
  logic cpuHalt, clkGateEn, oscEn, strobeForce, aleLevel, psenLevel;

  int nChecks = 0;
  int nFails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  pmc_top #(.NUM_EXT(NUM_EXT), .HOLD_CYCLES(HOLD)) u_pmc_top (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrData(regWrData),
    .irqPending(irqPending), .extIntN(extIntN), .extIntEn(extIntEn),
    .extLevelMode(extLevelMode), .oscStable(oscStable),
    .cpuHalt(cpuHalt), .clkGateEn(clkGateEn), .oscEn(oscEn),
    .strobeForce(strobeForce), .aleLevel(aleLevel), .psenLevel(psenLevel)
  );

  // table: {regWrEn, regWrData, irqPending, expected outputs}
  typedef struct packed {
    logic       wr;
    logic [7:0] data;
    logic       irq;
    logic [5:0] exp;
  } vec_t;
  localparam int NVEC = 7;
  localparam vec_t VECS [NVEC] = '{
    '{1'b1, 8'h00, 1'b0, O_RUN},   // R5 zero write
    '{1'b1, 8'h01, 1'b0, O_IDLE},  // R2 idle entry
    '{1'b0, 8'h00, 1'b0, O_IDLE},  // R2 idle holds
    '{1'b0, 8'h00, 1'b1, O_RUN},   // R6 idle exit
    '{1'b1, 8'h04, 1'b0, O_RUN},   // R5 unrelated bit
    '{1'b0, 8'h00, 1'b0, O_RUN},   // R5 still running
    '{1'b1, 8'h03, 1'b0, O_PD}     // R4 both bits
  };

  function automatic logic [5:0] outs();
    return {cpuHalt, clkGateEn, oscEn, strobeForce, aleLevel, psenLevel};
  endfunction

  task automatic check(string req, logic [5:0] exp);
    nChecks++;
    if (outs() !== exp) begin
      nFails++;
      $display("FAIL %s: outputs actual=%b expected=%b", req, outs(), exp);
    end
  endtask

  task automatic checkBit(string req, logic act, logic exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic step(logic wr, logic [7:0] data, logic irq);
    @(negedge clk);
    regWrEn = wr; regWrData = data; irqPending = irq;
    @(posedge clk); #1;
    regWrEn = 1'b0; irqPending = 1'b0;
  endtask

  task automatic holdLow(int n);
    @(negedge clk);
    extIntN[0] = 1'b0;
    repeat (n) @(posedge clk);
    @(negedge clk);
    extIntN[0] = 1'b1;
    @(posedge clk); #1;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", nChecks - nFails, nChecks);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nChecks++; nFails++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  initial begin
    #2;
    check("R1 in reset", O_RUN);
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R1 after reset", O_RUN);

    for (int i = 0; i < NVEC; i++) begin
      step(VECS[i].wr, VECS[i].data, VECS[i].irq);
      check($sformatf("table row %0d (R2/R4/R5/R6)", i), VECS[i].exp);
    end

    // R10: edge-mode pin, irq and disabled pin ignored in power-down
    @(negedge clk); extIntN[1] = 1'b0; irqPending = 1'b1; #1;
    checkBit("R10 edge pin osc", oscEn, 1'b0);
    repeat (20) @(posedge clk); #1;
    check("R10 edge pin and irq", O_PD);
    @(negedge clk); extIntN = 2'b11; irqPending = 1'b0;
    extIntEn = 2'b10; extIntN[0] = 1'b0; #1;
    checkBit("R10 disabled pin osc", oscEn, 1'b0);
    repeat (HOLD + 4) @(posedge clk);
    @(negedge clk); extIntN[0] = 1'b1; @(posedge clk); #1;
    check("R10 disabled pin held", O_PD);
    @(negedge clk); extIntEn = 2'b11;

    // R7: oscillator follows qualified pin at once
    @(negedge clk); extIntN[0] = 1'b0; #1;
    checkBit("R7 osc on", oscEn, 1'b1);
    @(negedge clk); extIntN[0] = 1'b1; #1;
    checkBit("R7 osc off", oscEn, 1'b0);
    @(posedge clk); #1;

    // R9: early release, twice (restart proven by no accumulation)
    holdLow(HOLD - 1);
    check("R9 early release 1", O_PD);
    holdLow(HOLD - 1);
    check("R9 early release 2", O_PD);

    // R8 / R12: exact hold, then oscillator-stable gating
    oscStable = 1'b0;
    holdLow(HOLD);
    check("R8 stabilise phase", O_STAB);
    repeat (5) step(1'b0, 8'h00, 1'b0);
    check("R12 waits for osc", O_STAB);
    @(negedge clk); oscStable = 1'b1;
    @(posedge clk); #1;
    check("R8 back to run", O_RUN);

    // R3 / R11
    step(1'b1, 8'h02, 1'b0);
    check("R3 power-down entry", O_PD);
    @(negedge clk); extIntN[0] = 1'b0;
    repeat (100) @(posedge clk);
    @(negedge clk); rstN = 1'b0; #1;
    check("R11 async reset", O_RUN);
    extIntN[0] = 1'b1;
    @(negedge clk); rstN = 1'b1;
    @(posedge clk); #1;
    check("R11 run after reset", O_RUN);

    finishRun();
  end
endmodule